// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer with Flush

This block holds recently used virtual-to-physical page translations. A 40-bit virtual address is split three ways. The low 14 bits are the page offset, and they pass straight through to the physical address. The remaining 26 bits are the virtual page number. The low 8 bits of that number pick one of 256 sets, and the upper 18 bits are compared against the stored tag of each of the two ways in that set. A matching valid entry gives its 22-bit physical page number and 3 rights bits in the same cycle. With no match, the block raises a miss so that a table walker can fetch the translation.

The walker returns the entry through a refill port. The entry is written in the cycle the refill is presented, into a way picked from the tag match, the valid bits and one least-recently-used bit per set. A flush pulse clears every valid bit in a single cycle, so nothing from the previous address space survives a context switch.

Top module: `tlb_sa`

## Requirements
- R1: The page number is va_i[39:14]. Its bits [7:0] (va_i[21:14]) select one of 256 sets, and its bits [25:8] (va_i[39:22]) are the tag. All 512 entries (256 sets by 2 ways) can hold distinct translations at the same time.
- R2: When lookup_i is high and a valid entry in the selected set holds the tag, hit_o is 1 in that same cycle. pa_o[35:14] carries that entry's page number and rights_o its rights bits.
- R3: pa_o[13:0] always equals va_i[13:0].
- R4: When lookup_i is high and no entry matches, miss_o is 1, hit_o is 0, and pa_o[35:14] and rights_o are 0. When lookup_i is low, hit_o and miss_o are both 0.
- R5: After reset every entry is invalid, so every lookup misses.
- R6: A refill writes the set selected by refill_vpn_i and takes effect at the next clock edge. The target way is chosen in this order: the way already holding the same tag; otherwise an invalid way, with way 0 before way 1; otherwise the way named by the set's LRU bit.
- R7: A hit sets the LRU bit of its set to the way that did not hit. A refill sets it to the way that was not written. When a hit and a refill touch the same set in one cycle, the refill's update wins.
- R8: A flush pulse makes every entry invalid from the next cycle on.
- R9: When flush_i and refill_i are high in the same cycle, the refill is dropped.
- R10: A lookup in the same cycle as a refill sees the contents from before that refill. The new entry hits from the following cycle.
- R11: A refill of a page number that is already present replaces that entry's page number and rights. The other way of the set keeps its entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_i | input | 1 | Translate va_i this cycle |
| va_i | input | 40 | Virtual address |
| hit_o | output | 1 | Translation found |
| miss_o | output | 1 | Translation absent; walk request |
| pa_o | output | 36 | Physical page number joined with the page offset |
| rights_o | output | 3 | Access-rights bits of the hit entry |
| refill_i | input | 1 | Write a translation |
| refill_vpn_i | input | 26 | Page number of the translation to write |
| refill_ppn_i | input | 22 | Physical page number to write |
| refill_rights_i | input | 3 | Rights bits to write |
| flush_i | input | 1 | Invalidate all entries |

## Verification
The bench fills all 512 entries and reads each one back. This would expose a wrong set/tag split, which would alias sets or drop entries. It then probes every set with an absent tag, to catch false hits. Short scripted sequences on a single set check the replacement order. A design that let the hit update beat the refill update, or that ignored the LRU bit, would evict the wrong translation, and the bench sees this when a later lookup hits or misses unexpectedly. Further checks cover a flush sharing a cycle with a refill, a lookup racing a refill, and an overwrite of a present page. A design that let the refill through, forwarded the new entry early, or created a duplicate entry would fail these.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_WAYS = 2;
  typedef logic [TLB_WAYS-1:0] way_vec_t;
endpackage

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int unsigned TAG_W    = 18,
  parameter int unsigned PPN_W    = 22,
  parameter int unsigned RIGHTS_W = 3,
  parameter int unsigned SETS     = 256,
  localparam int unsigned IDX_W   = $clog2(SETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic [IDX_W-1:0]    lk_idx_i,
  input  logic [TAG_W-1:0]    lk_tag_i,
  output logic                lk_hit_o,
  output logic [PPN_W-1:0]    lk_ppn_o,
  output logic [RIGHTS_W-1:0] lk_rights_o,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [TAG_W-1:0]    wr_tag_i,
  input  logic [PPN_W-1:0]    wr_ppn_i,
  input  logic [RIGHTS_W-1:0] wr_rights_i,
  output logic                wr_valid_o,
  output logic                wr_match_o
);
  logic [SETS-1:0]     valid_q;
  logic [TAG_W-1:0]    tag_q    [SETS];
  logic [PPN_W-1:0]    ppn_q    [SETS];
  logic [RIGHTS_W-1:0] rights_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]    <= wr_tag_i;
      ppn_q[wr_idx_i]    <= wr_ppn_i;
      rights_q[wr_idx_i] <= wr_rights_i;
    end
  end

  assign lk_hit_o    = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  assign lk_ppn_o    = ppn_q[lk_idx_i];
  assign lk_rights_o = rights_q[lk_idx_i];
  assign wr_valid_o  = valid_q[wr_idx_i];
  assign wr_match_o  = valid_q[wr_idx_i] && (tag_q[wr_idx_i] == wr_tag_i);
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl
  import tlb_pkg::*;
#(
  parameter int unsigned SETS  = 256,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_upd_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  logic             hit_way_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  way_vec_t         probe_valid_i,
  input  way_vec_t         probe_match_i,
  output way_vec_t         fill_vec_o
);
  // lru_q[s] names the way to evict next
  logic [SETS-1:0] lru_q;
  logic            fill_way;

  always_comb begin
    if (probe_match_i[1])       fill_way = 1'b1;
    else if (probe_match_i[0])  fill_way = 1'b0;
    else if (!probe_valid_i[0]) fill_way = 1'b0;
    else if (!probe_valid_i[1]) fill_way = 1'b1;
    else                        fill_way = lru_q[fill_idx_i];
  end

  assign fill_vec_o = fill_way ? way_vec_t'(2'b10) : way_vec_t'(2'b01);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lru_q <= '0;
    else begin
      if (hit_upd_i) lru_q[hit_idx_i]  <= ~hit_way_i;
      if (fill_i)    lru_q[fill_idx_i] <= ~fill_way;   // refill wins
    end
  end
endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W       = 40,
  parameter int unsigned PAGE_OFF_W = 14,
  parameter int unsigned PPN_W      = 22,
  parameter int unsigned RIGHTS_W   = 3,
  parameter int unsigned SETS       = 256,
  localparam int unsigned VPN_W     = VA_W - PAGE_OFF_W,
  localparam int unsigned IDX_W     = $clog2(SETS),
  localparam int unsigned TAG_W     = VPN_W - IDX_W,
  localparam int unsigned PA_W      = PPN_W + PAGE_OFF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lookup_i,
  input  logic [VA_W-1:0]     va_i,
  output logic                hit_o,
  output logic                miss_o,
  output logic [PA_W-1:0]     pa_o,
  output logic [RIGHTS_W-1:0] rights_o,
  input  logic                refill_i,
  input  logic [VPN_W-1:0]    refill_vpn_i,
  input  logic [PPN_W-1:0]    refill_ppn_i,
  input  logic [RIGHTS_W-1:0] refill_rights_i,
  input  logic                flush_i
);
  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;

  assign lk_vpn   = va_i[VA_W-1:PAGE_OFF_W];
  assign lk_idx   = lk_vpn[IDX_W-1:0];
  assign lk_tag   = lk_vpn[VPN_W-1:IDX_W];
  assign fill_idx = refill_vpn_i[IDX_W-1:0];
  assign fill_tag = refill_vpn_i[VPN_W-1:IDX_W];

  way_vec_t            way_hit, hit_vec, probe_valid, probe_match, fill_vec;
  logic [PPN_W-1:0]    way_ppn    [TLB_WAYS];
  logic [RIGHTS_W-1:0] way_rights [TLB_WAYS];
  logic                fill_en;

  assign fill_en = refill_i && !flush_i;

  for (genvar w = 0; w < TLB_WAYS; w++) begin : g_way
    tlb_way #(
      .TAG_W(TAG_W), .PPN_W(PPN_W), .RIGHTS_W(RIGHTS_W), .SETS(SETS)
    ) u_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .lk_idx_i   (lk_idx),
      .lk_tag_i   (lk_tag),
      .lk_hit_o   (way_hit[w]),
      .lk_ppn_o   (way_ppn[w]),
      .lk_rights_o(way_rights[w]),
      .wr_en_i    (fill_en && fill_vec[w]),
      .wr_idx_i   (fill_idx),
      .wr_tag_i   (fill_tag),
      .wr_ppn_i   (refill_ppn_i),
      .wr_rights_i(refill_rights_i),
      .wr_valid_o (probe_valid[w]),
      .wr_match_o (probe_match[w])
    );
  end

  assign hit_vec = way_hit & {TLB_WAYS{lookup_i}};

  logic [PPN_W-1:0]    sel_ppn;
  logic [RIGHTS_W-1:0] sel_rights;

  always_comb begin
    sel_ppn    = '0;
    sel_rights = '0;
    for (int w = 0; w < TLB_WAYS; w++) begin
      if (hit_vec[w]) begin
        sel_ppn    = sel_ppn | way_ppn[w];
        sel_rights = sel_rights | way_rights[w];
      end
    end
  end

  assign hit_o    = |hit_vec;
  assign miss_o   = lookup_i && !(|hit_vec);
  assign pa_o     = {sel_ppn, va_i[PAGE_OFF_W-1:0]};
  assign rights_o = sel_rights;

  tlb_repl #(.SETS(SETS)) u_repl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_upd_i    (|hit_vec),
    .hit_idx_i    (lk_idx),
    .hit_way_i    (hit_vec[1]),
    .fill_i       (fill_en),
    .fill_idx_i   (fill_idx),
    .probe_valid_i(probe_valid),
    .probe_match_i(probe_match),
    .fill_vec_o   (fill_vec)
  );
endmodule

// File: rtl/tlb_sa_chk.sv
module tlb_sa_chk #(
  parameter int unsigned VA_W       = 40,
  parameter int unsigned PAGE_OFF_W = 14,
  parameter int unsigned PPN_W      = 22,
  localparam int unsigned VPN_W     = VA_W - PAGE_OFF_W,
  localparam int unsigned PA_W      = PPN_W + PAGE_OFF_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lookup_i,
  input logic [VA_W-1:0]  va_i,
  input logic             hit_o,
  input logic             miss_o,
  input logic [PA_W-1:0]  pa_o,
  input logic             refill_i,
  input logic [VPN_W-1:0] refill_vpn_i,
  input logic [PPN_W-1:0] refill_ppn_i,
  input logic             flush_i,
  input logic [1:0]       hit_vec,
  input logic [1:0]       probe_valid,
  input logic [1:0]       probe_match,
  input logic [1:0]       fill_vec
);
  a_r4_hit_miss_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |-> (hit_o ^ miss_o));

  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |-> (!hit_o && !miss_o));

  a_r8_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);

  a_r10_refill_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(refill_i && !flush_i) && lookup_i &&
     va_i[VA_W-1:PAGE_OFF_W] == $past(refill_vpn_i))
    |-> (hit_o && pa_o[PA_W-1:PAGE_OFF_W] == $past(refill_ppn_i)));

  a_r11_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  a_r6_match_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_i && (|probe_match)) |-> (fill_vec == probe_match));

  a_r6_invalid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_i && !(|probe_match) && !(&probe_valid)) |-> (|(fill_vec & ~probe_valid)));
endmodule

bind tlb_sa tlb_sa_chk #(
  .VA_W(VA_W), .PAGE_OFF_W(PAGE_OFF_W), .PPN_W(PPN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lookup_i    (lookup_i),
  .va_i        (va_i),
  .hit_o       (hit_o),
  .miss_o      (miss_o),
  .pa_o        (pa_o),
  .refill_i    (refill_i),
  .refill_vpn_i(refill_vpn_i),
  .refill_ppn_i(refill_ppn_i),
  .flush_i     (flush_i),
  .hit_vec     (hit_vec),
  .probe_valid (probe_valid),
  .probe_match (probe_match),
  .fill_vec    (fill_vec)
);

// File: tb/sim_tlb_sa.sv
`timescale 1ns/1ps
module sim_tlb_sa;
  localparam int VA_W = 40, OFF_W = 14, PPN_W = 22, RW = 3, SETS = 256;
  localparam int VPN_W = VA_W - OFF_W, IDX_W = 8, TAG_W = VPN_W - IDX_W;
  localparam int PA_W = PPN_W + OFF_W;

  logic clk_i = 0, rst_ni = 0;
  logic lookup_i = 0, refill_i = 0, flush_i = 0;
  logic [VA_W-1:0]  va_i = '0;
  logic [VPN_W-1:0] refill_vpn_i = '0;
  logic [PPN_W-1:0] refill_ppn_i = '0;
  logic [RW-1:0]    refill_rights_i = '0;
  logic hit_o, miss_o;
  logic [PA_W-1:0] pa_o;
  logic [RW-1:0]   rights_o;

  int n_checks = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  tlb_sa u0 (
    .clk_i, .rst_ni, .lookup_i, .va_i, .hit_o, .miss_o, .pa_o, .rights_o,
    .refill_i, .refill_vpn_i, .refill_ppn_i, .refill_rights_i, .flush_i
  );

  function automatic logic [VPN_W-1:0] vpn_of(int s, int k);
    logic [TAG_W-1:0] t;
    t = TAG_W'(s * 5 + k * 977 + 7);
    return {t, IDX_W'(s)};
  endfunction
  function automatic logic [PPN_W-1:0] ppn_of(logic [VPN_W-1:0] v);
    return PPN_W'(v * 13 + 5);
  endfunction
  function automatic logic [RW-1:0] rt_of(logic [VPN_W-1:0] v);
    return v[2:0] ^ 3'b101;
  endfunction

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive a lookup, sample before the edge, then let the edge pass
  task automatic look_x(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] off, input bit e,
                        input logic [PPN_W-1:0] ep, input logic [RW-1:0] er, input string req);
    logic [PA_W-1:0] epa;
    lookup_i = 1; va_i = {v, off};
    #2;
    epa = e ? {ep, off} : {PPN_W'(0), off};
    chk({hit_o, miss_o} == {e, !e}, req, {hit_o, miss_o}, {e, !e});
    chk(pa_o == epa && rights_o == (e ? er : RW'(0)), req, {pa_o, rights_o}, {epa, (e ? er : RW'(0))});
    tick();
    lookup_i = 0;
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input bit e, input string req);
    look_x(v, OFF_W'(v * 3 + 11), e, ppn_of(v), rt_of(v), req);
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input bit fl);
    refill_i = 1; refill_vpn_i = v; refill_ppn_i = p; refill_rights_i = rt_of(v); flush_i = fl;
    tick();
    refill_i = 0; flush_i = 0;
  endtask

  task automatic flush();
    flush_i = 1; tick(); flush_i = 0;
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [VPN_W-1:0] a, b, c, d;
    #22 rst_ni = 1;
    tick();

    // R5: empty after reset; R4: idle outputs quiet
    for (int s = 0; s < 4; s++) look(vpn_of(s * 60, 0), 0, "R5 reset empty");
    va_i = {vpn_of(3, 0), 14'h3}; #2;
    chk(!hit_o && !miss_o, "R4 idle quiet", {hit_o, miss_o}, 2'b00);
    tick();

    // R1: fill every set/way, read all back (R2, R3)
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < 2; k++) fill(vpn_of(s, k), ppn_of(vpn_of(s, k)), 0);
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < 2; k++) look(vpn_of(s, k), 1, "R1 R2 R3 full sweep");
    // R4: absent tag in every set misses
    for (int s = 0; s < SETS; s++) look(vpn_of(s, 2), 0, "R4 absent tag");

    // R8: one flush empties everything
    flush();
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < 2; k++) look(vpn_of(s, k), 0, "R8 flush all");

    // R6 R7: hit steers victim; set 9
    a = vpn_of(9, 3); b = vpn_of(9, 4); c = vpn_of(9, 5); d = vpn_of(9, 6);
    fill(a, ppn_of(a), 0);   // invalid way 0
    fill(b, ppn_of(b), 0);   // invalid way 1
    look(a, 1, "R6 first fill kept");   // LRU -> way 1
    fill(c, ppn_of(c), 0);   // evicts b
    look(a, 1, "R7 hit protects entry");
    look(b, 0, "R7 lru way evicted");
    look(c, 1, "R6 refill present");

    // R7: refill update beats hit update in same cycle; set 40
    flush();
    a = vpn_of(40, 3); b = vpn_of(40, 4); c = vpn_of(40, 5); d = vpn_of(40, 6);
    fill(a, ppn_of(a), 0); fill(b, ppn_of(b), 0);   // LRU -> way 0 (a)
    lookup_i = 1; va_i = {b, 14'h21};
    refill_i = 1; refill_vpn_i = c; refill_ppn_i = ppn_of(c); refill_rights_i = rt_of(c);
    tick();                   // c replaces a; LRU -> way 1 (b)
    lookup_i = 0; refill_i = 0;
    fill(d, ppn_of(d), 0);    // should evict b
    look(a, 0, "R7 conflict victim a gone");
    look(b, 0, "R7 refill update wins");
    look(c, 1, "R7 conflict c kept");
    look(d, 1, "R7 conflict d present");

    // R11: overwrite a present page
    look_x(c, 14'h5, 1, ppn_of(c), rt_of(c), "R11 before overwrite");
    fill(c, 22'h2abcde, 0);
    look_x(c, 14'h5, 1, 22'h2abcde, rt_of(c), "R11 new ppn");
    look(d, 1, "R11 other way kept");

    // R10: same-cycle lookup sees old state
    a = vpn_of(77, 3);
    lookup_i = 1; va_i = {a, 14'h1f};
    refill_i = 1; refill_vpn_i = a; refill_ppn_i = ppn_of(a); refill_rights_i = rt_of(a);
    #2;
    chk(miss_o && !hit_o, "R10 lookup during refill", {hit_o, miss_o}, 2'b01);
    tick();
    refill_i = 0; lookup_i = 0;
    look(a, 1, "R10 visible next cycle");

    // R9: flush wins over refill
    b = vpn_of(120, 3);
    fill(b, ppn_of(b), 1);
    look(b, 0, "R9 refill dropped");
    look(a, 0, "R9 R8 flush cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule